// File: doc/BRIEF.md
# Pulse Event Counter with Snapshot Register

This block counts events that arrive as asynchronous pulses and keeps a frozen copy of the running count for a reader. All logic runs on one system clock. Every external pulse or strobe line is brought through a synchronizer. Events are then recognised as high-to-low transitions of the synchronized level.

Three lines feed the count: a primary pulse line and an alternate pulse line, which are ORed together, and a test line that advances only the upper half of the counter. A clear strobe (active low) zeroes the counter. A capture strobe (active low) copies the count into the snapshot register, which keeps that copy once the strobe is released. An elaboration option widens the snapshot with an external prescaler byte placed below the count. The top bit of that byte then acts as a further pulse source.

Top module: `pulse_snap_counter`

## Requirements
- R1: Each high-to-low transition of the effective count level adds exactly one to `count_q`. The change is visible on the third rising clock edge after the input falls: two synchronizer stages, then the counter register.
- R2: The effective count level is the OR of `cnt_a`, `cnt_b` and, in prescaler mode, `pre_byte` bit PRE_W-1. While any one of these is high, pulses on the others do not change the count. A count is taken only when the OR itself falls.
- R3: The counter wraps from all ones to zero and has no carry output.
- R4: While the synchronized `clr_n` is low, the counter goes to zero. Clear wins over any count or test event in the same cycle.
- R5: A high-to-low transition on `tst_cnt`, while count bit CNT_W/2-1 is 0, adds one to bits CNT_W-1..CNT_W/2 and leaves bits CNT_W/2-1..0 unchanged.
- R6: A `tst_cnt` transition while count bit CNT_W/2-1 is 1 has no effect.
- R7: While the synchronized `load_n` is low, `snap_q` takes the count on every clock. Once `load_n` is high, `snap_q` holds its value even as the counter moves.
- R8: When a count event and an active capture fall in the same clock cycle, the snapshot records the value from before that increment.
- R9: With EXT_PRE=1, `snap_q` is {count, synchronized `pre_byte`}, with the count in the upper CNT_W bits. A falling edge on `pre_byte` bit PRE_W-1 counts like the primary line.
- R10: While `rst_n` is low, the counter, the snapshot and all synchronizer and edge state are zero. The synchronizer stages for `clr_n` and `load_n` reset to their idle level of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| cnt_a | input | 1 | Primary count pulse line, asynchronous |
| cnt_b | input | 1 | Alternate count pulse line, asynchronous |
| tst_cnt | input | 1 | Upper-half test pulse line, asynchronous |
| clr_n | input | 1 | Counter clear strobe, active low, asynchronous |
| load_n | input | 1 | Snapshot capture strobe, active low, asynchronous |
| pre_byte | input | PRE_W | External prescaler byte, used when EXT_PRE=1 |
| count_q | output | CNT_W | Running count |
| snap_q | output | CNT_W + (EXT_PRE ? PRE_W : 0) | Snapshot register |

## Verification
Two functions can land in the same clock cycle: the capture strobe and a count increment, and also the clear strobe and a count increment. The bench makes them collide by driving the falling edge of the count line and a one-cycle low on the strobe at the same clock. Because both pass through synchronizers of equal depth, the two events reach the logic together. The bench then checks that the snapshot holds the value from before the increment while the counter moves on. A second run delays the strobe by one cycle, and the snapshot must then hold the incremented value. For the clear collision, the counter must read zero.

// File: rtl/psc_pkg.sv
package psc_pkg;

  // Advance a count by the primary step and, optionally, by one unit of the upper half.
  function automatic logic [63:0] psc_advance(input logic [63:0] cur, input logic main_inc,
                                              input logic up_inc, input int half);
    logic [63:0] up_unit;
    up_unit = up_inc ? (64'd1 << half) : 64'd0;
    return cur + 64'(main_inc) + up_unit;
  endfunction

  // The upper-half step is allowed only while the top bit of the lower half is clear.
  function automatic logic psc_gate_open(input logic [63:0] cur, input int half);
    return !cur[half-1];
  endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/psc_fall.sv
module psc_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign fall = prev & ~lvl;
endmodule

// File: rtl/psc_count_core.sv
module psc_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_act,
  input  logic             inc,
  input  logic             up_inc,
  output logic [CNT_W-1:0] count_q
);
  import psc_pkg::*;
  localparam int HALF = CNT_W / 2;

  logic up_ok;
  assign up_ok = up_inc && psc_gate_open(64'(count_q), HALF);

  always_ff @(posedge clk) begin
    if (!rst_n)              count_q <= '0;
    else if (clr_act)        count_q <= '0;
    else if (inc || up_ok)   count_q <= CNT_W'(psc_advance(64'(count_q), inc, up_ok, HALF));
  end
endmodule

// File: rtl/psc_snap_reg.sv
module psc_snap_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_act,
  input  logic [W-1:0] cap_d,
  output logic [W-1:0] snap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        snap_q <= '0;
    else if (load_act) snap_q <= cap_d;
  end
endmodule

// File: rtl/pulse_snap_counter.sv
module pulse_snap_counter #(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 8,
  parameter bit EXT_PRE     = 1'b1,
  parameter int SYNC_STAGES = 2,
  localparam int SNAP_W     = CNT_W + (EXT_PRE ? PRE_W : 0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_a,
  input  logic              cnt_b,
  input  logic              tst_cnt,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic [PRE_W-1:0]  pre_byte,
  output logic [CNT_W-1:0]  count_q,
  output logic [SNAP_W-1:0] snap_q
);
  localparam int CTRL_W = 5;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic              a_s, b_s, tst_s, clr_act, load_act;
  logic [PRE_W-1:0]  pre_s;
  logic              pre_cnt_s;
  logic              cnt_lvl, cnt_fall, tst_fall;
  logic [SNAP_W-1:0] cap_d;

  assign ctrl_raw = {load_n, clr_n, tst_cnt, cnt_b, cnt_a};

  psc_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b11000)) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  assign a_s      = ctrl_s[0];
  assign b_s      = ctrl_s[1];
  assign tst_s    = ctrl_s[2];
  assign clr_act  = ~ctrl_s[3];
  assign load_act = ~ctrl_s[4];

  generate
    if (EXT_PRE) begin : g_ext
      psc_sync #(.W(PRE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pre (
        .clk(clk), .rst_n(rst_n), .d(pre_byte), .q(pre_s)
      );
      assign pre_cnt_s = pre_s[PRE_W-1];
      assign cap_d     = {count_q, pre_s};
    end else begin : g_plain
      assign pre_s     = '0;
      assign pre_cnt_s = 1'b0;
      assign cap_d     = count_q;
    end
  endgenerate

  assign cnt_lvl = a_s | b_s | pre_cnt_s;

  psc_fall u_fall_cnt (.clk(clk), .rst_n(rst_n), .lvl(cnt_lvl), .fall(cnt_fall));
  psc_fall u_fall_tst (.clk(clk), .rst_n(rst_n), .lvl(tst_s),   .fall(tst_fall));

  psc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr_act(clr_act), .inc(cnt_fall),
    .up_inc(tst_fall), .count_q(count_q)
  );

  psc_snap_reg #(.W(SNAP_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load_act(load_act), .cap_d(cap_d), .snap_q(snap_q)
  );
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int CNT_W  = 32,
  parameter int SNAP_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_act,
  input logic              cnt_fall,
  input logic              tst_fall,
  input logic              load_act,
  input logic              cnt_lvl,
  input logic [CNT_W-1:0]  count_q,
  input logic [SNAP_W-1:0] snap_q
);
  localparam int HALF = CNT_W / 2;

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> count_q == '0);

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && cnt_fall && !tst_fall) |=> count_q == CNT_W'($past(count_q) + 1'b1));

  a_r2_fall_only_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fall |-> !cnt_lvl);

  a_r2_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !cnt_fall && !tst_fall) |=> $stable(count_q));

  a_r5_upper_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !cnt_fall && tst_fall && !count_q[HALF-1]) |=>
      (count_q[HALF-1:0] == $past(count_q[HALF-1:0])) &&
      (count_q[CNT_W-1:HALF] == (CNT_W-HALF)'($past(count_q[CNT_W-1:HALF]) + 1'b1)));

  a_r6_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_act && !cnt_fall && tst_fall && count_q[HALF-1]) |=> $stable(count_q));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_act |=> $stable(snap_q));

  a_r8_pre_increment: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |=> snap_q[SNAP_W-1 -: CNT_W] == $past(count_q));
endmodule

bind pulse_snap_counter psc_checker #(.CNT_W(CNT_W), .SNAP_W(SNAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_act(clr_act), .cnt_fall(cnt_fall), .tst_fall(tst_fall),
  .load_act(load_act), .cnt_lvl(cnt_lvl), .count_q(count_q), .snap_q(snap_q)
);

// File: tb/sim_pulse_snap_counter.sv
`timescale 1ns/1ps
module sim_pulse_snap_counter;
  localparam int W  = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic a = 0, b = 0, tst = 0, clr_n = 1, load_n = 1;
  logic [PW-1:0] pre0 = '0;
  logic [W-1:0]  cnt0, snap0;

  logic a1 = 0, ld1 = 1;
  logic [PW-1:0] pre1 = '0;
  logic [W-1:0]  cnt1;
  logic [W+PW-1:0] snap1;

  pulse_snap_counter #(.CNT_W(W), .PRE_W(PW), .EXT_PRE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_a(a), .cnt_b(b), .tst_cnt(tst), .clr_n(clr_n),
    .load_n(load_n), .pre_byte(pre0), .count_q(cnt0), .snap_q(snap0));

  pulse_snap_counter #(.CNT_W(W), .PRE_W(PW), .EXT_PRE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_a(a1), .cnt_b(1'b0), .tst_cnt(1'b0), .clr_n(1'b1),
    .load_n(ld1), .pre_byte(pre1), .count_q(cnt1), .snap_q(snap1));

  int n_cmp = 0, n_bad = 0;
  int exp0 = 0, exp1 = 0, held;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic pulse_a();  a = 1; tick(3); a = 0; tick(4); endtask
  task automatic pulse_b();  b = 1; tick(3); b = 0; tick(4); endtask
  task automatic pulse_t();  tst = 1; tick(3); tst = 0; tick(4); endtask
  task automatic pulse_ld(); load_n = 0; tick(1); load_n = 1; tick(4); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    chk("R10 reset count", cnt0, 0);
    chk("R10 reset snapshot", snap0, 0);
    chk("R10 reset snapshot ext", snap1, 0);
    rst_n = 1; tick(3);

    // R1: primary line steps
    for (int i = 0; i < 5; i++) begin
      pulse_a(); exp0++;
      chk("R1 primary step", cnt0, exp0);
    end

    // R2: alternate line counts, inhibit while the other is high
    for (int i = 0; i < 3; i++) begin
      pulse_b(); exp0++;
      chk("R2 alternate step", cnt0, exp0);
    end
    a = 1; tick(4);
    pulse_b(); pulse_b();
    chk("R2 inhibited by held line", cnt0, exp0);
    a = 0; tick(4); exp0++;
    chk("R2 count when OR falls", cnt0, exp0);

    // R4: clear
    clr_n = 0; tick(1); clr_n = 1; tick(4); exp0 = 0;
    chk("R4 clear", cnt0, exp0);

    // R5: upper-half step with gate open
    pulse_t(); exp0 = 16;
    chk("R5 test step from zero", cnt0, exp0);
    for (int i = 0; i < 3; i++) begin pulse_a(); exp0++; end
    pulse_t(); exp0 += 16;
    chk("R5 test step keeps lower half", cnt0, exp0);

    // R6: gate closed when bit 3 is set
    for (int i = 0; i < 5; i++) begin pulse_a(); exp0++; end
    chk("R6 setup lower bit3 set", cnt0 & 8'h08, 8'h08);
    pulse_t();
    chk("R6 test step ignored", cnt0, exp0);

    // R3: exhaustive sweep through the wrap
    clr_n = 0; tick(1); clr_n = 1; tick(4); exp0 = 0;
    for (int i = 0; i < 256; i++) begin
      pulse_a(); exp0 = (exp0 + 1) & 8'hFF;
      chk("R3 sweep", cnt0, exp0);
    end
    chk("R3 wrapped to zero", cnt0, 0);

    // R7: capture then hold
    for (int i = 0; i < 7; i++) begin pulse_a(); exp0++; end
    pulse_ld(); held = exp0;
    chk("R7 capture", snap0, held);
    for (int i = 0; i < 3; i++) begin pulse_a(); exp0++; end
    chk("R7 snapshot holds", snap0, held);
    chk("R7 counter moved", cnt0, exp0);

    // R8: capture and count edge in the same cycle
    a = 1; tick(4);
    a = 0; load_n = 0; tick(1); load_n = 1; tick(4);
    chk("R8 snapshot pre-increment", snap0, exp0);
    exp0++;
    chk("R8 counter incremented", cnt0, exp0);
    a = 1; tick(4);
    a = 0; tick(1); load_n = 0; tick(1); load_n = 1; tick(4); exp0++;
    chk("R8 later capture sees increment", snap0, exp0);

    // R4: clear colliding with a count edge
    a = 1; tick(4);
    a = 0; clr_n = 0; tick(1); clr_n = 1; tick(4); exp0 = 0;
    chk("R4 clear beats count", cnt0, exp0);

    // R9: prescaler mode
    for (int i = 0; i < 4; i++) begin
      pre1 = 4'h8; tick(3); pre1 = 4'h0; tick(4); exp1++;
      chk("R9 prescaler msb counts", cnt1, exp1);
    end
    a1 = 1; tick(4);
    pre1 = 4'h8; tick(3); pre1 = 4'h0; tick(4);
    chk("R9 R2 inhibited in prescaler mode", cnt1, exp1);
    a1 = 0; tick(4); exp1++;
    pre1 = 4'h5; tick(3);
    ld1 = 0; tick(1); ld1 = 1; tick(4);
    chk("R9 wide snapshot", snap1, (exp1 << PW) | 5);
    pre1 = 4'h2; tick(4);
    chk("R9 R7 wide snapshot holds", snap1, (exp1 << PW) | 5);

    summary();
    $finish;
  end
endmodule